// File: doc/BRIEF.md
# Bit-Serial Eight-Point Inverse Cosine Transform

This block computes an eight-point one-dimensional inverse cosine transform. It uses distributed arithmetic, so it needs no multiplier. A start pulse captures eight signed coefficients into holding registers. The next cycle copies them into shift registers, which then feed two bit planes per cycle to eight processing units. Each unit looks up two copies of a sixteen-word table of precomputed constant sums. One copy is addressed by the lower bit plane and the other by the upper one. The unit merges the two words with one adder and folds the result into a right-shifting accumulator.

After half as many steps as the coefficient has bits, four units hold the even-index half of the transform and four hold the odd-index half. A row of four adders and four subtractors then combines the halves, rounds each result and registers it into the output row. A one-cycle done pulse marks the new results. The amount of work per row is the same whatever the data are: zero coefficients take exactly as long as any others.

Top module: `daIdct8`

## Requirements
- R1: While reset is asserted and after its release, `doneOut` is low and every output lane reads zero until the first result is written.
- R2: If `startIn` is high at a rising edge while the block is idle, `doneOut` is high for exactly one cycle, starting at the eighth rising edge after that one (COEF_W/2 + 2 edges).
- R3: Input lane i is `coefIn[i*12 +: 12]`, holding coefficient X_i in two's complement. Output lane n is `dataOut[n*16 +: 16]`, in two's complement. Output n equals floor((S_n + 2048) / 4096), where S_n is the sum over k of X_k times K(k,n). K(k,n) is round-half-away-from-zero of 4096·c_k·cos((2n+1)kπ/16), with c_0 = 1/√8 and c_k = 1/2 otherwise. The result may differ from this by at most one.
- R4: The eight outputs come from four even-index sums E_m and four odd-index sums O_m, with output m = E_m + O_m and output 7−m = E_m − O_m (m = 0..3), rounded as in R3.
- R5: Full-scale inputs, all +2047, all −2048 and alternating signs, meet R3. This includes the sign-bit plane, which is weighted negatively.
- R6: An all-zero row gives all-zero outputs, with the same latency as R2.
- R7: A `startIn` pulse that arrives while a row is in progress is ignored. It changes neither the results nor the done timing, and it produces no extra done pulse.
- R8: `dataOut` holds its value from one done pulse until the next.
- R9: A start presented in the same cycle as `doneOut` is accepted, so rows can run back to back.
- R10: `coefIn` is sampled only at the accepted start edge. Later changes do not alter the row in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| startIn | input | 1 | Start pulse; sampled together with coefIn when idle |
| coefIn | input | 8*COEF_W | Eight packed two's-complement coefficients, lane 0 in the low bits |
| doneOut | output | 1 | One-cycle pulse when dataOut has been updated |
| dataOut | output | 8*OUT_W | Eight packed two's-complement results, lane 0 in the low bits |

## Verification
If a bit-plane shift register or an accumulator carries a wrong state, the output lanes on the very next done pulse will differ from the reference product by far more than one. A wrong sign-plane weight appears only for negative coefficients, so full-scale negative and alternating rows are run. A control fault appears at the ports in one of three ways: a done pulse on the wrong cycle, a second done pulse for one start, or an output row that changes between pulses. All three are visible within the nine cycles of a single row.

// File: rtl/daPkg.sv
`timescale 1ns/1ps
package daPkg;
  localparam int LANES      = 8;
  localparam int HALF_LANES = 4;
  localparam int CONST_FRAC = 12;
  localparam int ROM_W      = 16;

  typedef enum logic [1:0] {PH_IDLE, PH_LOAD, PH_ACC, PH_OUT} phase_t;

  typedef struct packed {
    logic captureHold;
    logic loadSlices;
    logic accStep;
    logic signStep;
    logic writeOut;
  } strobe_t;

  // rounded 4096-scaled cosine magnitudes, index = frequency k
  function automatic int kMag(input int k);
    case (k)
      0: return 1448;
      1: return 2009;
      2: return 1892;
      3: return 1703;
      4: return 1448;
      5: return 1138;
      6: return 784;
      default: return 400;
    endcase
  endfunction

  // unit u: 0..3 even half row u, 4..7 odd half row u-4; input j
  function automatic int weight(input int u, input int j);
    case (u * 4 + j)
      0, 4, 8, 12: return kMag(0);
      1:  return kMag(2);
      2:  return kMag(4);
      3:  return kMag(6);
      5:  return kMag(6);
      6:  return -kMag(4);
      7:  return -kMag(2);
      9:  return -kMag(6);
      10: return -kMag(4);
      11: return kMag(2);
      13: return -kMag(2);
      14: return kMag(4);
      15: return -kMag(6);
      16: return kMag(1);
      17: return kMag(3);
      18: return kMag(5);
      19: return kMag(7);
      20: return kMag(3);
      21: return -kMag(7);
      22: return -kMag(1);
      23: return -kMag(5);
      24: return kMag(5);
      25: return -kMag(1);
      26: return kMag(7);
      27: return kMag(3);
      28: return kMag(7);
      29: return -kMag(5);
      30: return kMag(3);
      default: return -kMag(1);
    endcase
  endfunction

  // table word: sum of the weights selected by the address bits
  function automatic logic signed [ROM_W-1:0] romWord(input int u, input logic [3:0] addr);
    int s;
    s = 0;
    for (int j = 0; j < 4; j++) begin
      if (addr[j]) s += weight(u, j);
    end
    return ROM_W'(s);
  endfunction
endpackage

// File: rtl/daUnit.sv
`timescale 1ns/1ps
module daUnit
  import daPkg::*;
#(
  parameter int COEF_W = 12,
  parameter int ACC_W  = 28,
  parameter int UNIT   = 0
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    clrIn,
  input  logic                    stepIn,
  input  logic                    signIn,
  input  logic [3:0]              addrLo,
  input  logic [3:0]              addrHi,
  output logic signed [ACC_W-1:0] accOut
);
  localparam int HALF = COEF_W / 2;
  localparam int PRE  = 2 * (HALF - 1);
  localparam int PW   = ROM_W + 2;

  logic signed [ROM_W-1:0] romLo, romHi;
  logic signed [PW-1:0]    part;

  always_comb begin
    romLo = romWord(UNIT, addrLo);
    romHi = romWord(UNIT, addrHi);
  end

  // merge both table halves; the top plane carries negative weight
  always_comb begin
    if (signIn) part = PW'(romLo) - (PW'(romHi) <<< 1);
    else        part = PW'(romLo) + (PW'(romHi) <<< 1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       accOut <= '0;
    else if (clrIn)  accOut <= '0;
    else if (stepIn) accOut <= (accOut >>> 2) + (ACC_W'(part) <<< PRE);
  end
endmodule

// File: rtl/daCtrl.sv
`timescale 1ns/1ps
module daCtrl
  import daPkg::*;
#(
  parameter int COEF_W = 12
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    startIn,
  output strobe_t strb,
  output logic    doneOut
);
  localparam int HALF  = COEF_W / 2;
  localparam int CNT_W = $clog2(HALF) + 1;
  localparam int LAT   = HALF + 2;

  phase_t           phase;
  logic [CNT_W-1:0] stepCnt;

  always_comb begin
    strb.captureHold = (phase == PH_IDLE) && startIn;
    strb.loadSlices  = (phase == PH_LOAD);
    strb.accStep     = (phase == PH_ACC);
    strb.signStep    = (phase == PH_ACC) && (stepCnt == CNT_W'(HALF - 1));
    strb.writeOut    = (phase == PH_OUT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      stepCnt <= '0;
      doneOut <= 1'b0;
    end else begin
      doneOut <= strb.writeOut;
      case (phase)
        PH_IDLE: if (startIn) phase <= PH_LOAD;
        PH_LOAD: begin
          stepCnt <= '0;
          phase   <= PH_ACC;
        end
        PH_ACC: begin
          stepCnt <= stepCnt + 1'b1;
          if (stepCnt == CNT_W'(HALF - 1)) phase <= PH_OUT;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // checker: count edges from an accepted start to the done pulse
  logic [CNT_W+1:0] chkCnt;
  logic             chkRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chkCnt <= '0;
      chkRun <= 1'b0;
    end else if (strb.captureHold) begin
      chkCnt <= '0;
      chkRun <= 1'b1;
    end else if (chkRun) begin
      chkCnt <= chkCnt + 1'b1;
      if (doneOut) chkRun <= 1'b0;
    end
  end

  // R2
  done_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> (chkRun && chkCnt == (CNT_W+2)'(LAT)));

  // R2
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut);
endmodule

// File: rtl/daDatapath.sv
`timescale 1ns/1ps
module daDatapath
  import daPkg::*;
#(
  parameter int COEF_W = 12,
  parameter int OUT_W  = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  strobe_t                   strb,
  input  logic [LANES*COEF_W-1:0]   coefIn,
  output logic [LANES*OUT_W-1:0]    dataOut
);
  localparam int ACC_W    = ROM_W + COEF_W;
  localparam int SUM_W    = ACC_W + 1;
  localparam int HALF_ULP = 1 << (CONST_FRAC - 1);

  logic [COEF_W-1:0]       hold   [LANES];
  logic [COEF_W-1:0]       slices [LANES];
  logic signed [ACC_W-1:0] accVal [LANES];
  logic signed [OUT_W-1:0] outRow [LANES];

  function automatic logic signed [OUT_W-1:0] roundOut(input logic signed [SUM_W-1:0] v);
    logic signed [SUM_W-1:0] t;
    t = v + SUM_W'(HALF_ULP);
    return OUT_W'(t >>> CONST_FRAC);
  endfunction

  // holding registers, then parallel load into the bit-plane shifters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < LANES; i++) begin
        hold[i]   <= '0;
        slices[i] <= '0;
      end
    end else begin
      for (int i = 0; i < LANES; i++) begin
        if (strb.captureHold)     hold[i]   <= coefIn[i*COEF_W +: COEF_W];
        if (strb.loadSlices)      slices[i] <= hold[i];
        else if (strb.accStep)    slices[i] <= slices[i] >> 2;
      end
    end
  end

  for (genvar u = 0; u < LANES; u++) begin : g_unit
    localparam int PAR = (u >= HALF_LANES) ? 1 : 0;
    logic [3:0] aLo, aHi;
    for (genvar j = 0; j < 4; j++) begin : g_addr
      assign aLo[j] = slices[2*j+PAR][0];
      assign aHi[j] = slices[2*j+PAR][1];
    end
    daUnit #(.COEF_W(COEF_W), .ACC_W(ACC_W), .UNIT(u)) u_unit (
      .clk   (clk),
      .rstN  (rstN),
      .clrIn (strb.loadSlices),
      .stepIn(strb.accStep),
      .signIn(strb.signStep),
      .addrLo(aLo),
      .addrHi(aHi),
      .accOut(accVal[u])
    );
  end

  // butterfly: four adders to the low rows, four subtractors mirrored
  for (genvar m = 0; m < HALF_LANES; m++) begin : g_bfly
    logic signed [SUM_W-1:0] sumV, difV;
    assign sumV = SUM_W'(accVal[m]) + SUM_W'(accVal[m+HALF_LANES]);
    assign difV = SUM_W'(accVal[m]) - SUM_W'(accVal[m+HALF_LANES]);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        outRow[m]         <= '0;
        outRow[LANES-1-m] <= '0;
      end else if (strb.writeOut) begin
        outRow[m]         <= roundOut(sumV);
        outRow[LANES-1-m] <= roundOut(difV);
      end
    end
  end

  for (genvar n = 0; n < LANES; n++) begin : g_out
    assign dataOut[n*OUT_W +: OUT_W] = outRow[n];
  end

  logic slicesEmpty;
  always_comb begin
    slicesEmpty = 1'b1;
    for (int i = 0; i < LANES; i++) if (slices[i] != '0) slicesEmpty = 1'b0;
  end

  // R2
  slices_drained_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.writeOut |-> slicesEmpty);
endmodule

// File: rtl/daIdct8.sv
`timescale 1ns/1ps
module daIdct8
  import daPkg::*;
#(
  parameter int COEF_W = 12,
  parameter int OUT_W  = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    startIn,
  input  logic [8*COEF_W-1:0]     coefIn,
  output logic                    doneOut,
  output logic [8*OUT_W-1:0]      dataOut
);
  strobe_t strb;

  daCtrl #(.COEF_W(COEF_W)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .startIn(startIn),
    .strb   (strb),
    .doneOut(doneOut)
  );

  daDatapath #(.COEF_W(COEF_W), .OUT_W(OUT_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .coefIn (coefIn),
    .dataOut(dataOut)
  );

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !doneOut |-> $stable(dataOut));
endmodule

// File: tb/sim_daIdct8.sv
`timescale 1ns/1ps
module sim_daIdct8;
  localparam int CW = 12;
  localparam int OW = 16;
  localparam int N  = 8;
  typedef logic [N*OW-1:0] vec_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startIn = 1'b0;
  logic [N*CW-1:0] coefIn = '0;
  logic doneOut;
  logic [N*OW-1:0] dataOut;

  always #2.5 clk = ~clk;

  daIdct8 #(.COEF_W(CW), .OUT_W(OW)) u0 (
    .clk(clk), .rstN(rstN), .startIn(startIn), .coefIn(coefIn),
    .doneOut(doneOut), .dataOut(dataOut)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int kTab [8][8];
  vec_t expQ[$];
  int dueQ[$];
  string tagQ[$];
  vec_t lastExp = '0;
  int rng = 32'h1234_5678;

  task automatic chk(input string req, input bit ok, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic vec_t refRow(input int x[8]);
    vec_t r;
    for (int n = 0; n < N; n++) begin
      longint s = 0;
      for (int k = 0; k < N; k++) s += longint'(x[k]) * longint'(kTab[k][n]);
      r[n*OW +: OW] = OW'((s + 2048) >>> 12);
    end
    return r;
  endfunction

  // caller is at a falling edge
  task automatic launch(input int x[8], input string tag);
    for (int i = 0; i < N; i++) coefIn[i*CW +: CW] = CW'(x[i]);
    startIn = 1'b1;
    expQ.push_back(refRow(x));
    dueQ.push_back(cyc + 9);
    tagQ.push_back(tag);
    @(negedge clk);
    startIn = 1'b0;
  endtask

  task automatic waitDone();
    do @(negedge clk); while (!doneOut);
  endtask

  task automatic runRow(input int x[8], input string tag);
    launch(x, tag);
    waitDone();
  endtask

  function automatic int nextRand();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >>> 17);
    rng = rng ^ (rng << 5);
    return (rng & 4095) - 2048;
  endfunction

  // scoreboard monitor
  logic prevDone = 1'b0;
  initial begin
    forever begin
      vec_t e;
      int due;
      string t;
      @(negedge clk);
      if (rstN && doneOut) begin
        chk("R2 done longer than one cycle", !prevDone, 1, 0);
        if (expQ.size() == 0) begin
          chk("R7 unexpected done", 1'b0, 1, 0);
        end else begin
          e = expQ.pop_front();
          due = dueQ.pop_front();
          t = tagQ.pop_front();
          chk({t, " R2 done cycle"}, cyc == due, cyc, due);
          for (int n = 0; n < N; n++) begin
            int a, x;
            a = int'(signed'(dataOut[n*OW +: OW]));
            x = int'(signed'(e[n*OW +: OW]));
            chk($sformatf("%s R4 lane %0d", t, n), (a - x <= 1) && (x - a <= 1), a, x);
          end
          lastExp = e;
        end
      end
      prevDone = doneOut;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R2 watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int x[8];
    for (int k = 0; k < N; k++) begin
      for (int n = 0; n < N; n++) begin
        real v;
        v = 4096.0 * ((k == 0) ? 1.0 / $sqrt(8.0) : 0.5) * $cos((2 * n + 1) * k * 3.14159265358979 / 16.0);
        kTab[k][n] = (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
      end
    end

    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 done in reset", doneOut == 1'b0, doneOut, 0);
    chk("R1 outputs in reset", dataOut == '0, 1, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 done after reset", doneOut == 1'b0, doneOut, 0);
    chk("R1 outputs after reset", dataOut == '0, 1, 0);

    // R3 single nonzero coefficients
    x = '{1000, 0, 0, 0, 0, 0, 0, 0};   runRow(x, "R3 dc");
    x = '{0, -700, 0, 0, 0, 0, 0, 0};   runRow(x, "R3 first odd");
    x = '{0, 0, 0, 0, 0, 0, 0, 1500};   runRow(x, "R3 highest");
    x = '{-300, 200, -100, 50, 400, -600, 700, -800}; runRow(x, "R3 mixed");

    // R5 full scale and sign plane
    x = '{2047, 2047, 2047, 2047, 2047, 2047, 2047, 2047};         runRow(x, "R5 max");
    x = '{-2048, -2048, -2048, -2048, -2048, -2048, -2048, -2048}; runRow(x, "R5 min");
    x = '{-2048, 2047, -2048, 2047, -2048, 2047, -2048, 2047};     runRow(x, "R5 alternating");
    x = '{-1, -1, -1, -1, -1, -1, -1, -1};                         runRow(x, "R5 minus one");

    // R6 zero row, fixed latency checked by the monitor
    x = '{0, 0, 0, 0, 0, 0, 0, 0};      runRow(x, "R6 zero");

    // R7 and R10: start pulses and coefficient changes while busy
    x = '{900, -450, 300, -150, 75, -30, 10, -5};
    launch(x, "R7 R10 busy");
    for (int i = 0; i < 4; i++) begin
      for (int l = 0; l < N; l++) coefIn[l*CW +: CW] = CW'(nextRand());
      startIn = 1'b1;
      @(negedge clk);
    end
    startIn = 1'b0;
    waitDone();

    // R8 hold between pulses
    repeat (6) @(negedge clk);
    for (int n = 0; n < N; n++)
      chk($sformatf("R8 hold lane %0d", n), dataOut[n*OW +: OW] == lastExp[n*OW +: OW],
          int'(signed'(dataOut[n*OW +: OW])), int'(signed'(lastExp[n*OW +: OW])));

    // R9 back to back: start in the done cycle
    for (int l = 0; l < N; l++) x[l] = nextRand();
    launch(x, "R9 chain 0");
    for (int b = 1; b < 5; b++) begin
      waitDone();
      for (int l = 0; l < N; l++) x[l] = nextRand();
      launch(x, $sformatf("R9 chain %0d", b));
    end
    waitDone();

    // R3 random rows
    for (int b = 0; b < 16; b++) begin
      for (int l = 0; l < N; l++) x[l] = nextRand();
      runRow(x, $sformatf("R3 random %0d", b));
    end

    repeat (12) @(negedge clk);
    chk("R2 missing done", expQ.size() == 0, expQ.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule